// File: doc/BRIEF.md
# Saturating Lane Adder for 128-bit Vectors

This block performs element-wise saturating arithmetic on 128-bit vectors. A vector is split into lanes of 8, 16, 32 or 64 bits. Each lane can add or subtract two operands, or accumulate an addend of the opposite signedness into a destination value. Every result is clamped to the range of the destination type rather than wrapping. When any active lane clamps, a sticky saturation bit in a 32-bit status word is set and stays set until reset.

Two masking controls narrow the work. Scalar mode keeps lane 0 only. Half-width mode keeps the lower 64 bits only. Masked lanes read as zero and cannot set the saturation bit. The unit is a single registered stage. A one-cycle `start_i` strobe captures the operands, and the result appears with `valid_o` on the following cycle. There is no back-pressure. The result register is overwritten only by the next `start_i` and holds its value until then, so a consumer takes it in the `valid_o` cycle or at any time before the next strobe.

Top module: `satv_alu`

## Requirements
- R1: With `op_i`=00 (add) or 01 (subtract, A minus B) and `signed_i`=1, each lane computes A op B as two's-complement numbers. A result above the lane maximum becomes 2^(W-1)-1, and a result below the lane minimum becomes -2^(W-1).
- R2: With `signed_i`=0, add clamps to all-ones when the true sum exceeds 2^W-1. Subtract clamps to zero when A is less than B.
- R3: With `op_i[1]`=1 and `signed_i`=1 (signed accumulate), each lane computes D plus A, with D read as signed and A read as unsigned. A result above the signed maximum clamps to 2^(W-1)-1. The result never clamps to the minimum.
- R4: With `op_i[1]`=1 and `signed_i`=0 (unsigned accumulate), each lane computes D plus A, with D read as unsigned and A read as signed. The result clamps to all-ones above 2^W-1 and to zero below 0. A negative A added to a D above the signed maximum returns the plain sum with no clamp.
- R5: Bit 27 of `status_o` is set in the cycle after a `start_i` in which any active lane clamps. It stays set until reset. All other status bits read zero.
- R6: With `scalar_i`=1, only lane 0 is computed. All other result bits are zero, and clamping in other lanes does not set the status bit.
- R7: With `half_i`=1 (and `scalar_i`=0), result bits 127:64 are zero, and clamping in those lanes does not set the status bit.
- R8: `valid_o` is high exactly in the cycle after each `start_i`. `result_o` changes only after a `start_i` and otherwise holds its value.
- R9: After reset, `valid_o`, `result_o` and `status_o` are all zero.
- R10: `size_i` selects the lane width: 0 selects 8 bits, 1 selects 16, 2 selects 32 and 3 selects 64. In every mode, each lane's result is placed at the bit position it occupies in the input vectors.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Capture operands and compute |
| size_i | input | 2 | Lane width code |
| op_i | input | 2 | 00 add, 01 subtract, 1x accumulate |
| signed_i | input | 1 | Destination type is signed |
| scalar_i | input | 1 | Compute lane 0 only |
| half_i | input | 1 | Compute lower 64 bits only |
| a_i | input | 128 | Operand A (addend when accumulating) |
| b_i | input | 128 | Operand B |
| d_i | input | 128 | Current destination value |
| result_o | output | 128 | Registered lane results |
| valid_o | output | 1 | Result valid, one cycle after start |
| status_o | output | 32 | Status word, sticky saturation at bit 27 |

## Verification
The bench uses the default parameters: a 128-bit vector, a 32-bit status word, and the saturation bit at position 27. At this width all four lane sizes are present, from sixteen 8-bit lanes down to two 64-bit lanes. That puts the 64-bit sign and carry edges within reach, together with half-width masking that drops exactly half the lanes of each size. Random operands drawn from boundary bytes (0x00, 0x01, 0x7F, 0x80, 0xFF) hit clamping in every mode often.

// File: rtl/satv_pkg.sv
package satv_pkg;
  // Number of selectable lane widths (8 << code).
  localparam int SIZE_CODES = 4;

  // Operation codes on op_i.
  localparam logic [1:0] OPC_ADD = 2'b00;
  localparam logic [1:0] OPC_SUB = 2'b01;

  function automatic int lane_width(input int code);
    return 8 << code;
  endfunction
endpackage

// File: rtl/satv_lane.sv
module satv_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] d_i,
  input  logic         is_sub_i,
  input  logic         is_acc_i,
  input  logic         signed_i,
  output logic [W-1:0] res_o,
  output logic         sat_o
);
  localparam int XW = W + 2;

  logic [W-1:0]         x_raw, y_raw;
  logic                 x_sx, y_sx;
  logic signed [XW-1:0] x_ext, y_ext, sum, hi_lim, lo_lim;
  logic                 over, under;

  always_comb begin
    // Accumulate: destination plus addend of opposite signedness.
    x_raw  = is_acc_i ? d_i : a_i;
    y_raw  = is_acc_i ? a_i : b_i;
    x_sx   = signed_i & x_raw[W-1];
    y_sx   = (is_acc_i ? ~signed_i : signed_i) & y_raw[W-1];
    x_ext  = $signed({{2{x_sx}}, x_raw});
    y_ext  = $signed({{2{y_sx}}, y_raw});
    sum    = is_sub_i ? (x_ext - y_ext) : (x_ext + y_ext);
    hi_lim = signed_i ? $signed({3'b000, {(W-1){1'b1}}}) : $signed({2'b00, {W{1'b1}}});
    lo_lim = signed_i ? $signed({3'b111, {(W-1){1'b0}}}) : '0;
    over   = sum > hi_lim;
    under  = sum < lo_lim;
    if (over)       res_o = hi_lim[W-1:0];
    else if (under) res_o = lo_lim[W-1:0];
    else            res_o = sum[W-1:0];
    sat_o  = over | under;
  end
endmodule

// File: rtl/satv_bank.sv
module satv_bank #(
  parameter int VEC_W = 128,
  parameter int W     = 8
) (
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  input  logic [VEC_W-1:0] d_i,
  input  logic             is_sub_i,
  input  logic             is_acc_i,
  input  logic             signed_i,
  input  logic             scalar_i,
  input  logic             half_i,
  output logic [VEC_W-1:0] res_o,
  output logic             sat_o
);
  localparam int LANES      = VEC_W / W;
  localparam int HALF_LANES = (LANES / 2 > 0) ? LANES / 2 : 1;

  logic [LANES-1:0] lane_sat;
  logic [LANES-1:0] lane_act;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [W-1:0] r;
    satv_lane #(.W(W)) u_lane (
      .a_i      (a_i[g*W +: W]),
      .b_i      (b_i[g*W +: W]),
      .d_i      (d_i[g*W +: W]),
      .is_sub_i (is_sub_i),
      .is_acc_i (is_acc_i),
      .signed_i (signed_i),
      .res_o    (r),
      .sat_o    (lane_sat[g])
    );
    assign lane_act[g] = scalar_i ? (g == 0) : (half_i ? (g < HALF_LANES) : 1'b1);
    assign res_o[g*W +: W] = lane_act[g] ? r : '0;
  end

  assign sat_o = |(lane_sat & lane_act);
endmodule

// File: rtl/satv_alu.sv
module satv_alu
  import satv_pkg::*;
#(
  parameter int VEC_W    = 128,
  parameter int STATUS_W = 32,
  parameter int SAT_BIT  = 27
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [1:0]          size_i,
  input  logic [1:0]          op_i,
  input  logic                signed_i,
  input  logic                scalar_i,
  input  logic                half_i,
  input  logic [VEC_W-1:0]    a_i,
  input  logic [VEC_W-1:0]    b_i,
  input  logic [VEC_W-1:0]    d_i,
  output logic [VEC_W-1:0]    result_o,
  output logic                valid_o,
  output logic [STATUS_W-1:0] status_o
);
  localparam int HALF_W = VEC_W / 2;

  logic                  is_sub, is_acc;
  logic [VEC_W-1:0]      bank_res [SIZE_CODES];
  logic [SIZE_CODES-1:0] bank_sat;
  logic [VEC_W-1:0]      sel_res;
  logic                  sel_sat;
  logic [VEC_W-1:0]      res_q;
  logic                  valid_q, sticky_q;

  assign is_acc = op_i[1];
  assign is_sub = (op_i == OPC_SUB);

  // One bank of lanes per element width; size_i picks the bank.
  for (genvar s = 0; s < SIZE_CODES; s++) begin : g_size
    satv_bank #(.VEC_W(VEC_W), .W(lane_width(s))) u_bank (
      .a_i      (a_i),
      .b_i      (b_i),
      .d_i      (d_i),
      .is_sub_i (is_sub),
      .is_acc_i (is_acc),
      .signed_i (signed_i),
      .scalar_i (scalar_i),
      .half_i   (half_i),
      .res_o    (bank_res[s]),
      .sat_o    (bank_sat[s])
    );
  end

  assign sel_res = bank_res[size_i];
  assign sel_sat = bank_sat[size_i];

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      res_q    <= '0;
      valid_q  <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      valid_q <= start_i;
      if (start_i) res_q <= sel_res;
      if (start_i && sel_sat) sticky_q <= 1'b1;
    end
  end

  always_comb begin
    status_o          = '0;
    status_o[SAT_BIT] = sticky_q;
  end

  assign result_o = res_q;
  assign valid_o  = valid_q;

  AST_VALID_FOLLOWS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o); // R8
  AST_NO_STRAY_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !valid_o); // R8
  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(result_o)); // R8
  AST_STICKY_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[SAT_BIT] |=> status_o[SAT_BIT]); // R5
  AST_STICKY_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[SAT_BIT]) |-> $past(start_i)); // R5
  AST_SCALAR_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(scalar_i)) |-> (result_o[VEC_W-1:HALF_W] == '0)); // R6
  AST_HALF_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(half_i)) |-> (result_o[VEC_W-1:HALF_W] == '0)); // R7
endmodule

// File: tb/test_satv_alu.sv
module test_satv_alu;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   size = '0, op = '0;
  logic         sg = 1'b0, sc = 1'b0, hf = 1'b0;
  logic [127:0] a = '0, b = '0, d = '0;
  logic [127:0] result;
  logic         valid;
  logic [31:0]  status;

  int  total = 0, fails = 0, cyc = 0;
  bit  done = 1'b0;
  logic exp_sticky = 1'b0;

  always #10 clk = ~clk;

  satv_alu i_satv_alu (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .size_i(size), .op_i(op),
    .signed_i(sg), .scalar_i(sc), .half_i(hf), .a_i(a), .b_i(b), .d_i(d),
    .result_o(result), .valid_o(valid), .status_o(status)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      total++; fails++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic check(input string tag, input string what, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic signed [65:0] ext_val(input logic [63:0] v, input int w, input logic sx);
    logic signed [65:0] t;
    t = '0;
    for (int i = 0; i < 66; i++) t[i] = (i < w) ? v[i] : (sx & v[w-1]);
    return t;
  endfunction

  // Returns {saturated, 64-bit lane result}.
  function automatic logic [64:0] ref_lane(input int w, input logic [63:0] la, lb, ld,
                                           input logic [1:0] lop, input logic lsg);
    logic signed [65:0] x, y, s, hi, lo;
    logic [63:0] mask;
    logic sat;
    x  = ext_val(lop[1] ? ld : la, w, lsg);
    y  = ext_val(lop[1] ? la : lb, w, lop[1] ? !lsg : lsg);
    s  = (lop == 2'b01) ? x - y : x + y;
    hi = lsg ? ((66'sd1 <<< (w-1)) - 66'sd1) : ((66'sd1 <<< w) - 66'sd1);
    lo = lsg ? -(66'sd1 <<< (w-1)) : 66'sd0;
    sat = 1'b1;
    if (s > hi) s = hi;
    else if (s < lo) s = lo;
    else sat = 1'b0;
    mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    return {sat, s[63:0] & mask};
  endfunction

  function automatic logic [128:0] ref_vec(input logic [1:0] vsz, vop, input logic vsg, vsc, vhf,
                                           input logic [127:0] va, vb, vd);
    int w, n;
    logic [127:0] r;
    logic any;
    w = 8 << vsz; n = 128 / w; r = '0; any = 1'b0;
    for (int l = 0; l < n; l++) begin
      logic act;
      logic [63:0] la, lb, ld;
      logic [64:0] lr;
      act = vsc ? (l == 0) : (vhf ? (l < n / 2) : 1'b1);
      la = '0; lb = '0; ld = '0;
      for (int k = 0; k < w; k++) begin
        la[k] = va[l*w+k]; lb[k] = vb[l*w+k]; ld[k] = vd[l*w+k];
      end
      lr = ref_lane(w, la, lb, ld, vop, vsg);
      if (act) begin
        for (int k = 0; k < w; k++) r[l*w+k] = lr[k];
        any |= lr[64];
      end
    end
    return {any, r};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_sticky = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_op(input string tag, input logic [1:0] tsz, top, input logic tsg, tsc, thf,
                       input logic [127:0] ta, tb, td, input logic [127:0] exp_res, input logic exp_sat);
    @(negedge clk);
    size = tsz; op = top; sg = tsg; sc = tsc; hf = thf; a = ta; b = tb; d = td;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    exp_sticky |= exp_sat;
    check(tag, "valid", {127'd0, valid}, 128'd1);
    check(tag, "result", result, exp_res);
    check("R5", "status", {96'd0, status}, {96'd0, 4'b0, exp_sticky, 27'd0});
  endtask

  function automatic logic [127:0] corner_vec();
    logic [127:0] v;
    logic [7:0] pick [5] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF};
    for (int i = 0; i < 16; i++) v[i*8 +: 8] = pick[$urandom % 5];
    return v;
  endfunction

  initial begin
    void'($urandom(32'h5A17));
    do_reset();
    // R9: reset state
    check("R9", "valid", {127'd0, valid}, 128'd0);
    check("R9", "result", result, 128'd0);
    check("R9", "status", {96'd0, status}, 128'd0);

    // R1 signed add and subtract, R10 lane sizes
    do_op("R1", 2'd0, 2'b00, 1, 0, 0, {16{8'h7F}}, {16{8'h01}}, '0, {16{8'h7F}}, 1);
    do_op("R1", 2'd1, 2'b00, 1, 0, 0, {8{16'h8000}}, {8{16'hFFFF}}, '0, {8{16'h8000}}, 1);
    do_op("R1", 2'd0, 2'b01, 1, 0, 0, {16{8'h80}}, {16{8'h01}}, '0, {16{8'h80}}, 1);
    do_op("R10", 2'd2, 2'b01, 1, 0, 0, {4{32'd5}}, {4{32'd7}}, '0, {4{32'hFFFF_FFFE}}, 0);
    // R2 unsigned
    do_op("R2", 2'd1, 2'b00, 0, 0, 0, {8{16'hFFFF}}, {8{16'h0002}}, '0, {8{16'hFFFF}}, 1);
    do_op("R2", 2'd2, 2'b01, 0, 0, 0, {4{32'd3}}, {4{32'd5}}, '0, 128'd0, 1);
    // R3 signed accumulate
    do_op("R3", 2'd3, 2'b10, 1, 0, 0, {2{64'h20}}, '0, {2{64'h7FFF_FFFF_FFFF_FFF0}},
          {2{64'h7FFF_FFFF_FFFF_FFFF}}, 1);
    do_op("R3", 2'd3, 2'b10, 1, 0, 0, {2{64'hFFFF_FFFF_FFFF_FFFF}}, '0, {2{64'h8000_0000_0000_0000}},
          {2{64'h7FFF_FFFF_FFFF_FFFF}}, 0);
    // R4 unsigned accumulate
    do_op("R4", 2'd3, 2'b11, 0, 0, 0, {2{64'hFFFF_FFFF_FFFF_FFFF}}, '0, {2{64'hFFFF_FFFF_FFFF_FFF0}},
          {2{64'hFFFF_FFFF_FFFF_FFEF}}, 0);
    do_op("R4", 2'd0, 2'b10, 0, 0, 0, {16{8'hFA}}, '0, {16{8'h05}}, 128'd0, 1);
    do_op("R4", 2'd0, 2'b10, 0, 0, 0, {16{8'h7F}}, '0, {16{8'hF0}}, {16{8'hFF}}, 1);

    // R6 scalar: upper lanes would clamp, flag must stay clear
    do_reset();
    do_op("R6", 2'd1, 2'b00, 1, 1, 0, {{7{16'h7FFF}}, 16'h0001}, {{7{16'h0001}}, 16'h0001}, '0,
          128'd2, 0);
    // R7 half width
    do_op("R7", 2'd2, 2'b00, 0, 0, 1, {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd1, 32'd2},
          {32'd1, 32'd1, 32'd3, 32'd4}, '0, {64'd0, 32'd4, 32'd6}, 0);
    // R8 hold without start
    a = ~a; b = ~b;
    repeat (3) @(negedge clk);
    check("R8", "valid idle", {127'd0, valid}, 128'd0);
    check("R8", "result held", result, {64'd0, 32'd4, 32'd6});

    // Random mix
    for (int it = 0; it < 400; it++) begin
      logic [1:0] rsz, rop;
      logic rsg, rsc, rhf;
      logic [127:0] ra, rb, rd;
      logic [128:0] ex;
      string tag;
      rsz = 2'($urandom % 4); rop = 2'($urandom % 4); rsg = 1'($urandom % 2);
      rsc = ($urandom % 8) == 0; rhf = ($urandom % 4) == 0;
      if ($urandom % 2) begin
        ra = corner_vec(); rb = corner_vec(); rd = corner_vec();
      end else begin
        ra = {$urandom, $urandom, $urandom, $urandom};
        rb = {$urandom, $urandom, $urandom, $urandom};
        rd = {$urandom, $urandom, $urandom, $urandom};
      end
      ex = ref_vec(rsz, rop, rsg, rsc, rhf, ra, rb, rd);
      tag = rop[1] ? (rsg ? "R3" : "R4") : (rsg ? "R1" : "R2");
      do_op(tag, rsz, rop, rsg, rsc, rhf, ra, rb, rd, ex[127:0], ex[128]);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule